// File: doc/BRIEF.md
# Memory Barrier Ordering Tracker

This block keeps memory references in an in-order, multi-threaded execute stage correctly ordered against full memory barriers. Each instruction carries a 32-bit execution sequence number. When a barrier issues, the tracker stores that number as the thread's outstanding barrier. When a memory reference issues, the tracker gives back the sequence number the reference has to wait for. This is the larger of the dependency number supplied by the register scoreboard and the thread's outstanding barrier.

Memory references may leave their functional unit for the load/store queue before they reach the head of the in-order queue. A per-slot early-issue flag controls this. The flag is raised when a reference is pushed into a memory functional unit. It is dropped if an early attempt faults, so the reference then waits until it reaches the head. Each cycle the tracker answers two questions. The first is whether the candidate at the front of the memory unit may go early. The second is whether the instruction at the head of the queue may commit. A barrier commits only when the store buffer has room. A non-faulting reference is held while an older barrier is still incomplete.

A barrier-completion event clears the outstanding barrier so that later references are no longer held. A sequence number of zero means no barrier is outstanding, and sequence-number wrap-around is not handled.

Top module: `mbar_order_track`

## Requirements
- R1: After reset, every thread has no outstanding barrier (value 0) and every early-issue flag is clear.
- R2: A barrier issue for thread t with sequence number s makes s the outstanding barrier of t from the next cycle onward. Other threads are not affected.
- R3: `ref_wait_for` equals the larger of `ref_sb_wait` and the outstanding barrier of thread `ref_tid`, where 0 means none.
- R4: When a barrier issues for thread `ref_tid` in the same cycle, `ref_wait_for` already uses that barrier's sequence number in place of the stored one.
- R5: A push with `push_vld` sets the early-issue flag of slot `push_tag` from the next cycle onward.
- R6: An early-issue fault on slot `fault_tag` clears that slot's flag from the next cycle onward. If a push to the same slot happens in the same cycle, the push wins and the flag is set.
- R7: `early_ok` is 1 exactly when early issue is enabled by parameter, `cand_vld` is 1, the flag of slot `cand_tag` is set, and `head_seq` is strictly greater than `cand_wait`.
- R8: A head instruction with `cmt_is_ref`=1 and `cmt_fault`=0 has `cmt_ok`=0 while its thread's outstanding barrier is nonzero and smaller than `cmt_seq`. Otherwise it has `cmt_ok`=`cmt_vld`. A faulting reference is never held.
- R9: A head instruction with `cmt_is_bar`=1 has `cmt_ok`=1 only when `cmt_vld` and `sb_space` are both 1.
- R10: A head instruction that is neither a reference nor a barrier has `cmt_ok`=`cmt_vld`. With `cmt_vld`=0, `cmt_ok` is 0.
- R11: A barrier completion for thread t with sequence number s clears t's outstanding barrier only if the stored value equals s. A completion with any other number is ignored.
- R12: A barrier issue and a completion for the same thread and the same sequence number in one cycle leave the thread with no outstanding barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_iss_vld | input | 1 | A full barrier issues this cycle |
| bar_iss_tid | input | TID_W | Thread of the issuing barrier |
| bar_iss_seq | input | SEQ_W | Sequence number of the issuing barrier |
| bar_done_vld | input | 1 | A barrier completes this cycle |
| bar_done_tid | input | TID_W | Thread of the completing barrier |
| bar_done_seq | input | SEQ_W | Sequence number of the completing barrier |
| ref_tid | input | TID_W | Thread of the memory reference being issued |
| ref_sb_wait | input | SEQ_W | Scoreboard dependency sequence number of that reference |
| ref_wait_for | output | SEQ_W | Sequence number the reference must wait for |
| push_vld | input | 1 | A reference is pushed into a memory unit slot |
| push_tag | input | TAG_W | Slot receiving the push |
| fault_vld | input | 1 | An early-issued reference faulted |
| fault_tag | input | TAG_W | Slot of the faulting reference |
| cand_vld | input | 1 | A reference sits at the front of a memory unit |
| cand_tag | input | TAG_W | Slot of that candidate |
| cand_wait | input | SEQ_W | Wait-for value of the candidate |
| head_seq | input | SEQ_W | Sequence number at the head of the in-order queue |
| early_ok | output | 1 | Candidate may go to the load/store queue early |
| cmt_vld | input | 1 | A head instruction is offered for commit |
| cmt_tid | input | TID_W | Thread of the head instruction |
| cmt_seq | input | SEQ_W | Sequence number of the head instruction |
| cmt_is_ref | input | 1 | Head instruction is a memory reference |
| cmt_is_bar | input | 1 | Head instruction is a full barrier |
| cmt_fault | input | 1 | Head instruction carries a fault |
| sb_space | input | 1 | Store buffer can accept a barrier |
| cmt_ok | output | 1 | Head instruction may commit this cycle |

## Verification
The hardest situations to reach from the ports are the collisions. One is a barrier issuing and completing with the same number in one cycle. Another is a completion carrying a stale number that must be ignored. A third is a push and a fault landing on the same slot. Random traffic alone rarely lines these up. The stimulus therefore draws sequence numbers from a narrow range, reuses the last issued barrier number for completions most of the time, and limits slots to eight. Directed cycles are added that force each collision and the forwarding of a same-cycle barrier into the wait-for value.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
   typedef enum logic [1:0] {
      HK_NONE  = 2'd0,
      HK_OTHER = 2'd1,
      HK_REF   = 2'd2,
      HK_BAR   = 2'd3
   } head_kind_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mbt_bar_slot.sv
module mbt_bar_slot #(
   parameter int unsigned SEQ_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss,
   input  logic [SEQ_W-1:0] iss_seq,
   input  logic             done,
   input  logic [SEQ_W-1:0] done_seq,
   output logic [SEQ_W-1:0] last
);
   logic [SEQ_W-1:0] last_q, after_iss, last_d;

   always_comb begin
      after_iss = iss ? iss_seq : last_q;
      last_d    = after_iss;
      if (done && (done_seq == after_iss)) last_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= last_d;
   end

   assign last = last_q;

   a_r2_bar_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (iss && !(done && done_seq == iss_seq)) |=> (last == $past(iss_seq)));

   a_r11_stale_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss && done && done_seq != last) |=> $stable(last));

   a_r12_same_cycle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (iss && done && done_seq == iss_seq) |=> (last == '0));
endmodule

// File: rtl/mbt_flag_tbl.sv
module mbt_flag_tbl #(
   parameter int unsigned TAGS  = 8,
   parameter int unsigned TAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_vld,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             fault_vld,
   input  logic [TAG_W-1:0] fault_tag,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_flag
);
   logic [TAGS-1:0] flag_q;

   for (genvar g = 0; g < TAGS; g++) begin : g_slot
      logic hit_push, hit_fault;
      assign hit_push  = push_vld  && (push_tag  == TAG_W'(g));
      assign hit_fault = fault_vld && (fault_tag == TAG_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)         flag_q[g] <= 1'b0;
         else if (hit_push)  flag_q[g] <= 1'b1;
         else if (hit_fault) flag_q[g] <= 1'b0;
      end
   end

   assign rd_flag = (32'(rd_tag) < TAGS) ? flag_q[rd_tag] : 1'b0;

   a_r5_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld |=> flag_q[$past(push_tag)]);

   a_r6_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld && !(push_vld && push_tag == fault_tag)) |=> !flag_q[$past(fault_tag)]);
endmodule

// File: rtl/mbt_decide.sv
module mbt_decide #(
   parameter int unsigned SEQ_W    = 32,
   parameter bit          EARLY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cand_vld,
   input  logic             cand_flag,
   input  logic [SEQ_W-1:0] cand_wait,
   input  logic [SEQ_W-1:0] head_seq,
   output logic             early_ok,
   input  logic             cmt_vld,
   input  logic [SEQ_W-1:0] cmt_seq,
   input  logic [SEQ_W-1:0] cmt_bar,
   input  logic             cmt_is_ref,
   input  logic             cmt_is_bar,
   input  logic             cmt_fault,
   input  logic             sb_space,
   output logic             cmt_ok
);
   import mbt_pkg::*;

   head_kind_e kind;
   logic       bar_pending_older;

   if (EARLY_EN) begin : g_early
      assign early_ok = cand_vld && cand_flag && (head_seq > cand_wait);
   end else begin : g_no_early
      logic unused_early;
      assign unused_early = ^{cand_vld, cand_flag, cand_wait, head_seq};
      assign early_ok = 1'b0;
   end

   always_comb begin
      if (!cmt_vld)        kind = HK_NONE;
      else if (cmt_is_bar) kind = HK_BAR;
      else if (cmt_is_ref) kind = HK_REF;
      else                 kind = HK_OTHER;
   end

   assign bar_pending_older = (cmt_bar != '0) && (cmt_bar < cmt_seq);

   always_comb begin
      unique case (kind)
         HK_NONE:  cmt_ok = 1'b0;
         HK_BAR:   cmt_ok = sb_space;
         HK_REF:   cmt_ok = cmt_fault || !bar_pending_older;
         default:  cmt_ok = 1'b1;
      endcase
   end

   a_r7_early_order: assert property (@(posedge clk) disable iff (!rst_n)
      early_ok |-> (cand_vld && cand_flag && head_seq > cand_wait));

   a_r8_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_ok && cmt_is_ref && !cmt_is_bar && !cmt_fault) |-> !(cmt_bar != '0 && cmt_bar < cmt_seq));

   a_r9_bar_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_ok && cmt_is_bar) |-> sb_space);

   a_r10_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !cmt_vld |-> !cmt_ok);
endmodule

// File: rtl/mbar_order_track.sv
module mbar_order_track #(
   parameter int unsigned THREADS  = 2,
   parameter int unsigned SEQ_W    = 32,
   parameter int unsigned TAGS     = 8,
   parameter bit          EARLY_EN = 1'b1,
   localparam int unsigned TID_W   = mbt_pkg::idx_w(THREADS),
   localparam int unsigned TAG_W   = mbt_pkg::idx_w(TAGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bar_iss_vld,
   input  logic [TID_W-1:0] bar_iss_tid,
   input  logic [SEQ_W-1:0] bar_iss_seq,
   input  logic             bar_done_vld,
   input  logic [TID_W-1:0] bar_done_tid,
   input  logic [SEQ_W-1:0] bar_done_seq,
   input  logic [TID_W-1:0] ref_tid,
   input  logic [SEQ_W-1:0] ref_sb_wait,
   output logic [SEQ_W-1:0] ref_wait_for,
   input  logic             push_vld,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             fault_vld,
   input  logic [TAG_W-1:0] fault_tag,
   input  logic             cand_vld,
   input  logic [TAG_W-1:0] cand_tag,
   input  logic [SEQ_W-1:0] cand_wait,
   input  logic [SEQ_W-1:0] head_seq,
   output logic             early_ok,
   input  logic             cmt_vld,
   input  logic [TID_W-1:0] cmt_tid,
   input  logic [SEQ_W-1:0] cmt_seq,
   input  logic             cmt_is_ref,
   input  logic             cmt_is_bar,
   input  logic             cmt_fault,
   input  logic             sb_space,
   output logic             cmt_ok
);
   initial begin
      if (THREADS < 1)  $error("THREADS must be at least 1");
      if (SEQ_W < 8)    $error("SEQ_W must be at least 8");
      if (TAGS < 2)     $error("TAGS must be at least 2");
   end

   logic [SEQ_W-1:0] last_bar [THREADS];
   logic [SEQ_W-1:0] stored_ref, bar_for_ref, cmt_bar;
   logic             cand_flag;

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      mbt_bar_slot #(.SEQ_W(SEQ_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .iss      (bar_iss_vld  && (bar_iss_tid  == TID_W'(t))),
         .iss_seq  (bar_iss_seq),
         .done     (bar_done_vld && (bar_done_tid == TID_W'(t))),
         .done_seq (bar_done_seq),
         .last     (last_bar[t])
      );
   end

   assign stored_ref  = (32'(ref_tid) < THREADS) ? last_bar[ref_tid] : '0;
   assign cmt_bar     = (32'(cmt_tid) < THREADS) ? last_bar[cmt_tid] : '0;
   assign bar_for_ref = (bar_iss_vld && bar_iss_tid == ref_tid) ? bar_iss_seq : stored_ref;
   assign ref_wait_for = (bar_for_ref > ref_sb_wait) ? bar_for_ref : ref_sb_wait;

   mbt_flag_tbl #(.TAGS(TAGS), .TAG_W(TAG_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_vld  (push_vld),
      .push_tag  (push_tag),
      .fault_vld (fault_vld),
      .fault_tag (fault_tag),
      .rd_tag    (cand_tag),
      .rd_flag   (cand_flag)
   );

   mbt_decide #(.SEQ_W(SEQ_W), .EARLY_EN(EARLY_EN)) u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand_vld   (cand_vld),
      .cand_flag  (cand_flag),
      .cand_wait  (cand_wait),
      .head_seq   (head_seq),
      .early_ok   (early_ok),
      .cmt_vld    (cmt_vld),
      .cmt_seq    (cmt_seq),
      .cmt_bar    (cmt_bar),
      .cmt_is_ref (cmt_is_ref),
      .cmt_is_bar (cmt_is_bar),
      .cmt_fault  (cmt_fault),
      .sb_space   (sb_space),
      .cmt_ok     (cmt_ok)
   );

   a_r3_wait_covers_scoreboard: assert property (@(posedge clk) disable iff (!rst_n)
      ref_wait_for >= ref_sb_wait);

   a_r4_forward_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_iss_vld && bar_iss_tid == ref_tid) |-> (ref_wait_for >= bar_iss_seq));
endmodule

// File: tb/sim_mbar_order_track.sv
module sim_mbar_order_track;
   localparam int NT = 2, SW = 32, NG = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          bar_iss_vld, bar_done_vld, push_vld, fault_vld, cand_vld;
   logic          cmt_vld, cmt_is_ref, cmt_is_bar, cmt_fault, sb_space;
   logic [0:0]    bar_iss_tid, bar_done_tid, ref_tid, cmt_tid;
   logic [SW-1:0] bar_iss_seq, bar_done_seq, ref_sb_wait, cand_wait, head_seq, cmt_seq;
   logic [2:0]    push_tag, fault_tag, cand_tag;
   logic [SW-1:0] ref_wait_for;
   logic          early_ok, cmt_ok;

   mbar_order_track #(.THREADS(NT), .SEQ_W(SW), .TAGS(NG), .EARLY_EN(1'b1)) u0 (.*);

   int total = 0, bad = 0;
   logic [SW-1:0] m_bar [NT];
   logic          m_flag [NG];

   function automatic logic [SW-1:0] exp_wait();
      logic [SW-1:0] b;
      b = (bar_iss_vld && bar_iss_tid == ref_tid) ? bar_iss_seq : m_bar[ref_tid];
      return (b > ref_sb_wait) ? b : ref_sb_wait;
   endfunction

   function automatic logic exp_early();
      return cand_vld && m_flag[cand_tag] && (head_seq > cand_wait);
   endfunction

   function automatic logic exp_cmt();
      logic [SW-1:0] b;
      b = m_bar[cmt_tid];
      if (!cmt_vld) return 1'b0;
      if (cmt_is_bar) return sb_space;
      if (cmt_is_ref) return cmt_fault || !(b != 0 && b < cmt_seq);
      return 1'b1;
   endfunction

   task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      bar_iss_vld = 0; bar_done_vld = 0; push_vld = 0; fault_vld = 0; cand_vld = 0;
      cmt_vld = 0; cmt_is_ref = 0; cmt_is_bar = 0; cmt_fault = 0; sb_space = 0;
      bar_iss_tid = 0; bar_done_tid = 0; ref_tid = 0; cmt_tid = 0;
      bar_iss_seq = 0; bar_done_seq = 0; ref_sb_wait = 0; cand_wait = 0;
      head_seq = 0; cmt_seq = 0; push_tag = 0; fault_tag = 0; cand_tag = 0;
   endtask

   // inputs set at negedge; outputs checked 1 time unit later; model updated as the next edge will
   task automatic step(input string tag);
      logic [SW-1:0] nb;
      #1;
      chk({tag, " R3/R4 wait_for"}, ref_wait_for, exp_wait());
      chk({tag, " R7 early_ok"}, SW'(early_ok), SW'(exp_early()));
      chk({tag, " R8/R9/R10 cmt_ok"}, SW'(cmt_ok), SW'(exp_cmt()));
      for (int t = 0; t < NT; t++) begin
         nb = (bar_iss_vld && bar_iss_tid == t) ? bar_iss_seq : m_bar[t];
         if (bar_done_vld && bar_done_tid == t && bar_done_seq == nb) nb = 0;
         m_bar[t] = nb;
      end
      if (fault_vld) m_flag[fault_tag] = 1'b0;
      if (push_vld)  m_flag[push_tag]  = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd12345));
      idle();
      for (int t = 0; t < NT; t++) m_bar[t] = 0;
      for (int g = 0; g < NG; g++) m_flag[g] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state seen through the ports
      ref_sb_wait = 0; ref_tid = 1; #1;
      chk("R1 no barrier after reset", ref_wait_for, 0);
      cand_vld = 1; cand_tag = 5; head_seq = 100; cand_wait = 0; #1;
      chk("R1 flag clear after reset", SW'(early_ok), 0);
      idle(); @(negedge clk);

      // R2 / R4: barrier seq 20 on thread 0, forwarded the same cycle
      bar_iss_vld = 1; bar_iss_tid = 0; bar_iss_seq = 20; ref_tid = 0; ref_sb_wait = 5;
      step("R4 forward");
      idle(); ref_tid = 0; ref_sb_wait = 7; step("R2 recorded");
      ref_tid = 1; ref_sb_wait = 7; step("R2 other thread");
      // R8: reference seq 25 held by barrier 20; faulting one passes; older one passes
      cmt_vld = 1; cmt_tid = 0; cmt_is_ref = 1; cmt_seq = 25; step("R8 held");
      cmt_fault = 1; step("R8 fault passes");
      cmt_fault = 0; cmt_seq = 15; step("R8 older passes");
      // R9
      idle(); cmt_vld = 1; cmt_is_bar = 1; cmt_seq = 20; sb_space = 0; step("R9 no space");
      sb_space = 1; step("R9 space");
      // R11: stale completion ignored, then match clears
      idle(); bar_done_vld = 1; bar_done_tid = 0; bar_done_seq = 19; step("R11 stale");
      idle(); ref_tid = 0; step("R11 stale check");
      bar_done_vld = 1; bar_done_tid = 0; bar_done_seq = 20; step("R11 match");
      idle(); ref_tid = 0; ref_sb_wait = 3; step("R11 cleared");
      // R12: issue and complete together
      bar_iss_vld = 1; bar_iss_tid = 1; bar_iss_seq = 30;
      bar_done_vld = 1; bar_done_tid = 1; bar_done_seq = 30; step("R12 collide");
      idle(); ref_tid = 1; step("R12 cleared");
      // R5 / R6: push then fault; push and fault same slot
      push_vld = 1; push_tag = 3; step("R5 push");
      idle(); cand_vld = 1; cand_tag = 3; head_seq = 10; cand_wait = 9; step("R5/R7 early");
      head_seq = 9; step("R7 head equal");
      fault_vld = 1; fault_tag = 3; head_seq = 10; step("R6 fault");
      idle(); cand_vld = 1; cand_tag = 3; head_seq = 10; cand_wait = 2; step("R6 cleared");
      push_vld = 1; push_tag = 3; fault_vld = 1; fault_tag = 3; step("R6 collide");
      idle(); cand_vld = 1; cand_tag = 3; head_seq = 10; cand_wait = 2; step("R6 push wins");
      // R10
      idle(); cmt_vld = 1; step("R10 other");

      // random phase over a narrow sequence range
      for (int i = 0; i < 3000; i++) begin
         idle();
         bar_iss_vld  = ($urandom % 4) == 0;
         bar_iss_tid  = 1'($urandom);
         bar_iss_seq  = 1 + $urandom % 40;
         bar_done_vld = ($urandom % 3) == 0;
         bar_done_tid = 1'($urandom);
         bar_done_seq = (($urandom % 4) != 0) ? m_bar[bar_done_tid] :
                        (($urandom % 2) ? bar_iss_seq : SW'(1 + $urandom % 40));
         ref_tid      = 1'($urandom);
         ref_sb_wait  = (($urandom % 3) == 0) ? 0 : SW'($urandom % 40);
         push_vld     = ($urandom % 3) == 0;
         push_tag     = 3'($urandom);
         fault_vld    = ($urandom % 4) == 0;
         fault_tag    = (($urandom % 2) != 0) ? push_tag : 3'($urandom);
         cand_vld     = ($urandom % 4) != 0;
         cand_tag     = 3'($urandom);
         cand_wait    = $urandom % 40;
         head_seq     = $urandom % 40;
         cmt_vld      = ($urandom % 5) != 0;
         cmt_tid      = 1'($urandom);
         cmt_seq      = 1 + $urandom % 40;
         case ($urandom % 3)
            0: cmt_is_ref = 1;
            1: cmt_is_bar = 1;
            default: ;
         endcase
         cmt_fault    = ($urandom % 4) == 0;
         sb_space     = ($urandom % 2) != 0;
         step("random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule